// File: doc/BRIEF.md
# Serial Audio Slave Receiver with Phase-Length Check

This block receives a two-channel serial audio stream from an external clock master. The bit clock, word-select and data lines come in asynchronously. They are brought into the system clock domain through two flip-flops each, and the block samples data on each detected rising edge of the synchronised bit clock. A change in word-select starts a new phase: low means the left phase and high means the right phase. In each phase the block skips a programmed number of delay bits and then shifts in a programmed number of data bits, MSB first. The finished sample is presented right-justified on a parallel output, tagged with its phase.

The frame may be asymmetric. The left-phase length is programmed directly, and the right-phase length is the total frame length minus the left length. Each time a phase ends, its bit count is compared with the configured length, and any mismatch is flagged as a framing error against the phase that just ended. Each phase has its own status word with sample-ready, overrun and framing-error flags, and its own interrupt enable mask. Reception is started and stopped with single-cycle pulses. After a start, nothing is captured until the first word-select change, so a partial frame is never delivered.

Top module: `aud_serial_rx`

## Requirements
- R1: `busy_o` rises one cycle after a `start_i` pulse and falls one cycle after a `stop_i` pulse; `stop_i` wins when both are high. A start while already busy leaves reception undisturbed, and while idle the line inputs change no output.
- R2: After a start, no sample and no flag is produced until the first word-select change seen at a bit-clock rising edge; bits before it are ignored.
- R3: The bit captured at the rising edge where word-select changes is position 0 of the new phase; word-select 0 selects left and 1 selects right. A sample is `width` bits shifted in MSB first, presented right-justified on `sample_o`, with `sample_right_o` set for a right-phase sample.
- R4: Data capture in a phase covers positions `delay` to `delay+width-1`, using that phase's own delay and width settings (widths 8, 12, 16, 24 or 32).
- R5: Status bit 0 (value 0x01), sample ready, is set in the word of the phase whose sample just completed and cleared in the other word. A `rd_i` pulse clears it in both words.
- R6: Status bit 2 (value 0x04), overrun, is set in the completing phase's word when a sample completes while either sample-ready bit is set. The held sample is replaced.
- R7: Status bit 4 (value 0x10), framing error, is set in the word of the phase that ended when its bit count differs from the expected count: `left_len_i` for left, `frame_len_i - left_len_i` for right. The first phase after a start is not checked.
- R8: A one on `clr_ovr_i[p]` or `clr_ferr_i[p]` (p=0 left, p=1 right) clears that phase's overrun or framing-error bit; other status bits read zero.
- R9: `irq_o` is high exactly when some status bit of a phase is set together with the same bit of that phase's enable mask.
- R10: After reset, busy, sample, phase tag, both status words and the interrupt are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | External bit clock, asynchronous |
| ws_i | input | 1 | External word-select, asynchronous |
| sd_i | input | 1 | External serial data, asynchronous |
| start_i | input | 1 | Start reception pulse |
| stop_i | input | 1 | Stop reception pulse |
| frame_len_i | input | LEN_W | Total bits per frame |
| left_len_i | input | LEN_W | Bits in the left phase |
| width_l_i | input | WID_W | Left sample width |
| width_r_i | input | WID_W | Right sample width |
| delay_l_i | input | DLY_W | Left delay bits before data |
| delay_r_i | input | DLY_W | Right delay bits before data |
| rd_i | input | 1 | Sample read pulse, clears sample-ready |
| clr_ovr_i | input | 2 | Write-one-to-clear overrun, per phase |
| clr_ferr_i | input | 2 | Write-one-to-clear framing error, per phase |
| irq_en_l_i | input | ST_W | Left interrupt enable mask |
| irq_en_r_i | input | ST_W | Right interrupt enable mask |
| busy_o | output | 1 | Reception under way |
| sample_o | output | DATA_W | Last completed sample, right-justified |
| sample_right_o | output | 1 | Held sample came from the right phase |
| status_l_o | output | ST_W | Left status word |
| status_r_o | output | ST_W | Right status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that each bit-clock half period lasts several system clocks, so every edge survives synchronisation. They also assume that word-select and data change only while the bit clock is low. The stimulus holds each bit-clock half for six or seven system clocks and moves word-select and data only on the falling half. The assertions further assume that a read or clear pulse never coincides with a sample completion or framing event. The stimulus therefore issues reads and clears in the low half of a bit, well after the previous rising edge has been absorbed, and changes the frame configuration only while reception is stopped.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LEN_W   = 8;
  localparam int unsigned WID_W   = 6;
  localparam int unsigned DLY_W   = 4;
  localparam int unsigned ST_W    = 5;
  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_OVR  = 2;
  localparam int unsigned ST_FERR = 4;

  typedef enum logic {PH_LEFT = 1'b0, PH_RIGHT = 1'b1} phase_e;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic [1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[0], d_i[gi]};
    end
    assign q_o[gi] = st_q[1];
  end
endmodule

// File: rtl/aud_rx_engine.sv
module aud_rx_engine
  import aud_rx_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned LW  = LEN_W,
  parameter int unsigned WW  = WID_W,
  parameter int unsigned DLW = DLY_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_s_i,
  input  logic          ws_s_i,
  input  logic          sd_s_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [LW-1:0] frame_len_i,
  input  logic [LW-1:0] left_len_i,
  input  logic [WW-1:0] width_l_i,
  input  logic [WW-1:0] width_r_i,
  input  logic [DLW-1:0] delay_l_i,
  input  logic [DLW-1:0] delay_r_i,
  output logic          busy_o,
  output logic          done_o,
  output phase_e        done_phase_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output phase_e        ferr_phase_o
);
  logic          sck_q, running_q, primed_q, armed_q, ws_q;
  phase_e        phase_q, cur_ph;
  logic [LW-1:0] cnt_q, pos, lo, hi, exp_len;
  logic [DW-1:0] sh_q, base, nxt;
  logic          rise, trans, capture;

  assign rise    = running_q & sck_s_i & ~sck_q;
  assign trans   = rise & primed_q & (ws_s_i != ws_q);
  assign pos     = trans ? '0 : cnt_q;
  assign cur_ph  = trans ? phase_e'(ws_s_i) : phase_q;
  assign lo      = (cur_ph == PH_RIGHT) ? LW'(delay_r_i) : LW'(delay_l_i);
  assign hi      = lo + ((cur_ph == PH_RIGHT) ? LW'(width_r_i) : LW'(width_l_i));
  assign capture = rise & (armed_q | trans) & (pos >= lo) & (pos < hi);
  assign base    = trans ? '0 : sh_q;
  assign nxt     = (base << 1) | DW'(sd_s_i);
  // length expected for the phase that is ending
  assign exp_len = ws_q ? (frame_len_i - left_len_i) : left_len_i;

  assign busy_o       = running_q;
  assign done_o       = capture & (pos == hi - 1'b1);
  assign done_phase_o = cur_ph;
  assign data_o       = nxt;
  assign ferr_o       = trans & armed_q & (cnt_q != exp_len);
  assign ferr_phase_o = phase_e'(ws_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q     <= 1'b0;
      running_q <= 1'b0;
      primed_q  <= 1'b0;
      armed_q   <= 1'b0;
      ws_q      <= 1'b0;
      phase_q   <= PH_LEFT;
      cnt_q     <= '0;
      sh_q      <= '0;
    end else begin
      sck_q <= sck_s_i;
      if (stop_i) begin
        running_q <= 1'b0;
        primed_q  <= 1'b0;
        armed_q   <= 1'b0;
      end else begin
        if (start_i) running_q <= 1'b1;
        if (rise) begin
          primed_q <= 1'b1;
          ws_q     <= ws_s_i;
          if (trans) begin
            armed_q <= 1'b1;
            phase_q <= cur_ph;
            cnt_q   <= LW'(1);
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
          end
          sh_q <= capture ? nxt : base;
        end
      end
    end
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && !stop_i) |-> running_q); // R1
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i) |-> !running_q && !armed_q); // R1
  AST_ARM_NEEDS_PRIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(primed_q)); // R2
  AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> cnt_q != '0); // R7
endmodule

// File: rtl/aud_rx_report.sv
module aud_rx_report
  import aud_rx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = ST_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  phase_e        done_phase_i,
  input  logic [DW-1:0] data_i,
  input  logic          ferr_i,
  input  phase_e        ferr_phase_i,
  input  logic          rd_i,
  input  logic [1:0]    clr_ovr_i,
  input  logic [1:0]    clr_ferr_i,
  input  logic [SW-1:0] en_l_i,
  input  logic [SW-1:0] en_r_i,
  output logic [DW-1:0] sample_o,
  output logic          sample_right_o,
  output logic [SW-1:0] status_l_o,
  output logic [SW-1:0] status_r_o,
  output logic          irq_o
);
  logic [1:0][SW-1:0] st;
  logic               any_full;

  assign any_full = st[0][ST_FULL] | st[1][ST_FULL];

  for (genvar gp = 0; gp < 2; gp++) begin : g_ph
    logic          hit, err, full_q, ovr_q, ferr_q;
    logic [SW-1:0] w;
    assign hit = done_i && (done_phase_i == phase_e'(gp));
    assign err = ferr_i && (ferr_phase_i == phase_e'(gp));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
        ferr_q <= 1'b0;
      end else begin
        // any completion moves ownership of the single sample register
        if (done_i)    full_q <= hit;
        else if (rd_i) full_q <= 1'b0;
        if (hit && any_full)   ovr_q <= 1'b1;
        else if (clr_ovr_i[gp]) ovr_q <= 1'b0;
        if (err)                 ferr_q <= 1'b1;
        else if (clr_ferr_i[gp]) ferr_q <= 1'b0;
      end
    end

    always_comb begin
      w          = '0;
      w[ST_FULL] = full_q;
      w[ST_OVR]  = ovr_q;
      w[ST_FERR] = ferr_q;
    end
    assign st[gp] = w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o       <= '0;
      sample_right_o <= 1'b0;
    end else if (done_i) begin
      sample_o       <= data_i;
      sample_right_o <= (done_phase_i == PH_RIGHT);
    end
  end

  assign status_l_o = st[0];
  assign status_r_o = st[1];
  assign irq_o      = |((st[0] & en_l_i) | (st[1] & en_r_i));

  AST_FULL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st[0][ST_FULL], st[1][ST_FULL]})); // R5
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && !done_i) |-> !st[0][ST_FULL] && !st[1][ST_FULL]); // R5
  AST_OVR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(st[0][ST_OVR]) || $rose(st[1][ST_OVR])) |-> $past(any_full)); // R6
  AST_FERR_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_ferr_i[0] && !(ferr_i && ferr_phase_i == PH_LEFT)) |-> !st[0][ST_FERR]); // R8
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_l_o != '0) || (status_r_o != '0)); // R9
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned LW  = LEN_W,
  parameter int unsigned WW  = WID_W,
  parameter int unsigned DLW = DLY_W,
  parameter int unsigned SW  = ST_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sck_i,
  input  logic           ws_i,
  input  logic           sd_i,
  input  logic           start_i,
  input  logic           stop_i,
  input  logic [LW-1:0]  frame_len_i,
  input  logic [LW-1:0]  left_len_i,
  input  logic [WW-1:0]  width_l_i,
  input  logic [WW-1:0]  width_r_i,
  input  logic [DLW-1:0] delay_l_i,
  input  logic [DLW-1:0] delay_r_i,
  input  logic           rd_i,
  input  logic [1:0]     clr_ovr_i,
  input  logic [1:0]     clr_ferr_i,
  input  logic [SW-1:0]  irq_en_l_i,
  input  logic [SW-1:0]  irq_en_r_i,
  output logic           busy_o,
  output logic [DW-1:0]  sample_o,
  output logic           sample_right_o,
  output logic [SW-1:0]  status_l_o,
  output logic [SW-1:0]  status_r_o,
  output logic           irq_o
);
  logic [2:0]    line_s;
  logic          done, ferr;
  phase_e        done_ph, ferr_ph;
  logic [DW-1:0] data;

  aud_rx_sync #(.N(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   (line_s)
  );

  aud_rx_engine #(.DW(DW), .LW(LW), .WW(WW), .DLW(DLW)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_s_i     (line_s[2]),
    .ws_s_i      (line_s[1]),
    .sd_s_i      (line_s[0]),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .frame_len_i (frame_len_i),
    .left_len_i  (left_len_i),
    .width_l_i   (width_l_i),
    .width_r_i   (width_r_i),
    .delay_l_i   (delay_l_i),
    .delay_r_i   (delay_r_i),
    .busy_o      (busy_o),
    .done_o      (done),
    .done_phase_o(done_ph),
    .data_o      (data),
    .ferr_o      (ferr),
    .ferr_phase_o(ferr_ph)
  );

  aud_rx_report #(.DW(DW), .SW(SW)) u_report (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .done_i        (done),
    .done_phase_i  (done_ph),
    .data_i        (data),
    .ferr_i        (ferr),
    .ferr_phase_i  (ferr_ph),
    .rd_i          (rd_i),
    .clr_ovr_i     (clr_ovr_i),
    .clr_ferr_i    (clr_ferr_i),
    .en_l_i        (irq_en_l_i),
    .en_r_i        (irq_en_r_i),
    .sample_o      (sample_o),
    .sample_right_o(sample_right_o),
    .status_l_o    (status_l_o),
    .status_r_o    (status_r_o),
    .irq_o         (irq_o)
  );
endmodule

// File: tb/aud_serial_rx_test.sv
module aud_serial_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic        start = 1'b0, stop = 1'b0, rd = 1'b0;
  logic [7:0]  frame_len = 8'd48, left_len = 8'd24;
  logic [5:0]  wl = 6'd16, wr = 6'd16;
  logic [3:0]  dl = 4'd1, dr = 4'd1;
  logic [1:0]  clr_ovr = '0, clr_ferr = '0;
  logic [4:0]  en_l = '0, en_r = '0;
  logic        busy, sample_right, irq;
  logic [31:0] sample;
  logic [4:0]  status_l, status_r;

  always #2 clk = ~clk;

  aud_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .start_i(start), .stop_i(stop), .frame_len_i(frame_len), .left_len_i(left_len),
    .width_l_i(wl), .width_r_i(wr), .delay_l_i(dl), .delay_r_i(dr),
    .rd_i(rd), .clr_ovr_i(clr_ovr), .clr_ferr_i(clr_ferr),
    .irq_en_l_i(en_l), .irq_en_r_i(en_r),
    .busy_o(busy), .sample_o(sample), .sample_right_o(sample_right),
    .status_l_o(status_l), .status_r_o(status_r), .irq_o(irq)
  );

  int checks = 0, errors = 0, settle = 4;
  bit finished = 0, auto_rd = 0;

  // behavioural reference
  bit          m_run, m_primed, m_armed, m_wsp, m_ph, m_right;
  int          m_cnt;
  logic [31:0] m_acc, m_sample;
  bit          m_full[2], m_ovr[2], m_ferr[2];

  function automatic logic [4:0] mst(int p);
    return {m_ferr[p], 1'b0, m_ovr[p], 1'b0, m_full[p]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 busy", busy, m_run);
    chk("R3 sample", sample, m_sample);
    chk("R3 phase tag", sample_right, m_right);
    chk("R5 full left", status_l[0], m_full[0]);
    chk("R5 full right", status_r[0], m_full[1]);
    chk("R6 overrun left", status_l[2], m_ovr[0]);
    chk("R6 overrun right", status_r[2], m_ovr[1]);
    chk("R7 framing left", status_l[4], m_ferr[0]);
    chk("R7 framing right", status_r[4], m_ferr[1]);
    chk("R8 spare bits", {status_l[3], status_l[1], status_r[3], status_r[1]}, 0);
    chk("R9 irq", irq, |((mst(0) & en_l) | (mst(1) & en_r)));
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      if (settle == 0) compare_all();
      else settle--;
    end
  end

  task automatic model_rise(bit w_in, bit d_in);
    int pos, w, d;
    bit trans;
    if (!m_run) return;
    trans = m_primed && (w_in != m_wsp);
    if (trans) begin
      if (m_armed && m_cnt != (m_wsp ? int'(frame_len) - int'(left_len) : int'(left_len)))
        m_ferr[m_wsp] = 1;
      m_armed = 1; m_ph = w_in; pos = 0; m_cnt = 1; m_acc = '0;
    end else begin
      pos = m_cnt;
      if (m_cnt < 255) m_cnt++;
    end
    m_primed = 1; m_wsp = w_in;
    if (m_armed) begin
      w = m_ph ? int'(wr) : int'(wl);
      d = m_ph ? int'(dr) : int'(dl);
      if (pos >= d && pos < d + w) begin
        m_acc = {m_acc[30:0], d_in};
        if (pos == d + w - 1) begin
          if (m_full[0] || m_full[1]) m_ovr[m_ph] = 1;
          m_full[0] = (m_ph == 0); m_full[1] = (m_ph == 1);
          m_sample = m_acc; m_right = m_ph;
        end
      end
    end
  endtask

  task automatic tick(bit w_in, bit d_in);
    @(negedge clk); sck = 0; ws = w_in; sd = d_in; settle = 4;
    repeat (5) @(negedge clk);
    if (auto_rd && (m_full[0] || m_full[1])) begin
      rd = 1; m_full[0] = 0; m_full[1] = 0; settle = 4;
      @(negedge clk); rd = 0;
    end
    @(negedge clk); sck = 1; model_rise(w_in, d_in); settle = 4;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_phase(bit w_in, int nbits, int d, int w, logic [31:0] val);
    for (int i = 0; i < nbits; i++)
      tick(w_in, (i >= d && i < d + w) ? val[w - 1 - (i - d)] : 1'b0);
  endtask

  task automatic do_start();
    @(negedge clk); start = 1; m_run = 1; settle = 4;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1; m_run = 0; m_primed = 0; m_armed = 0; settle = 4;
    @(negedge clk); stop = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_rd();
    @(negedge clk); rd = 1; m_full[0] = 0; m_full[1] = 0; settle = 4;
    @(negedge clk); rd = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_clr(logic [1:0] o, logic [1:0] f);
    @(negedge clk); clr_ovr = o; clr_ferr = f; settle = 4;
    for (int p = 0; p < 2; p++) begin
      if (o[p]) m_ovr[p] = 0;
      if (f[p]) m_ferr[p] = 0;
    end
    @(negedge clk); clr_ovr = '0; clr_ferr = '0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 sample", sample, 0);
    chk("R10 tag", sample_right, 0);
    chk("R10 status", {status_l, status_r}, 0);
    chk("R10 irq", irq, 0);

    // symmetric 48-bit frame, delay 1, width 16
    en_l = 5'h15; en_r = 5'h00; auto_rd = 1;
    do_start();
    repeat (3) tick(1, 1);
    chk("R2 no status before transition", {status_l, status_r}, 0);
    chk("R2 no sample before transition", sample, 0);
    send_phase(0, 24, 1, 16, 32'hA5C3);
    chk("R3 left sample", sample, 32'hA5C3);
    chk("R3 left tag", sample_right, 0);
    send_phase(1, 24, 1, 16, 32'h3C5A);
    send_phase(0, 24, 1, 16, 32'h0FF0);
    send_phase(1, 24, 1, 16, 32'h8001);
    chk("R3 right sample", sample, 32'h8001);
    chk("R3 right tag", sample_right, 1);

    // asymmetric 40-bit frame
    do_stop();
    chk("R1 stop clears busy", busy, 0);
    frame_len = 8'd40; left_len = 8'd24; wl = 6'd24; dl = 4'd0; wr = 6'd12; dr = 4'd2;
    do_start();
    do_start();
    chk("R1 start idempotent", busy, 1);
    repeat (5) tick(0, 1);
    send_phase(1, 16, 2, 12, 32'hABC);
    chk("R4 delayed right sample", sample, 32'hABC);
    chk("R4 right tag", sample_right, 1);
    send_phase(0, 24, 0, 24, 32'h5A5A5A);
    chk("R3 24-bit left", sample, 32'h5A5A5A);
    send_phase(1, 16, 2, 12, 32'h123);
    chk("R7 no framing error on good lengths", {status_l[4], status_r[4]}, 0);

    // short left phase
    send_phase(0, 20, 0, 24, 32'hFFFFFF);
    send_phase(1, 16, 2, 12, 32'h456);
    chk("R7 short left flagged", status_l[4], 1);
    chk("R7 right not flagged", status_r[4], 0);
    chk("R9 irq from left framing", irq, 1);
    do_clr(2'b00, 2'b01);
    chk("R8 framing cleared", status_l[4], 0);
    // long right phase
    send_phase(0, 24, 0, 24, 32'h0F0F0F);
    send_phase(1, 18, 2, 12, 32'h789);
    send_phase(0, 24, 0, 24, 32'h111111);
    chk("R7 long right flagged", status_r[4], 1);
    do_clr(2'b00, 2'b10);

    // overrun without reads
    auto_rd = 0;
    do_rd();
    send_phase(1, 16, 2, 12, 32'hFED);
    send_phase(0, 24, 0, 24, 32'h222333);
    chk("R6 left overrun", status_l[2], 1);
    chk("R6 overwritten sample", sample, 32'h222333);
    chk("R5 full moved to left", {status_l[0], status_r[0]}, 2'b10);
    do_rd();
    chk("R5 read clears full", {status_l[0], status_r[0]}, 0);
    do_clr(2'b01, 2'b00);
    chk("R8 overrun cleared", status_l[2], 0);

    // widest and narrowest samples
    do_stop();
    frame_len = 8'd64; left_len = 8'd40; wl = 6'd32; dl = 4'd1; wr = 6'd8; dr = 4'd0;
    auto_rd = 1; en_r = 5'h05;
    do_start();
    repeat (2) tick(1, 0);
    send_phase(0, 40, 1, 32, 32'hDEADBEEF);
    chk("R4 32-bit left", sample, 32'hDEADBEEF);
    send_phase(1, 24, 0, 8, 32'h7E);
    chk("R4 8-bit right", sample, 32'h7E);
    send_phase(0, 40, 1, 32, 32'h80000001);
    chk("R3 wide sample", sample, 32'h80000001);

    // idle: line activity ignored
    do_stop();
    send_phase(1, 8, 0, 8, 32'hFF);
    send_phase(0, 8, 0, 8, 32'hFF);
    chk("R1 idle keeps sample", sample, 32'h80000001);
    chk("R1 idle busy low", busy, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule